// File: doc/BRIEF.md
# Compressed Index Vector Generator

This block turns a vector mask into a packed list of element offsets, ready to feed the index operand of an indexed gather or scatter. After a start request it latches the mask, the vector length, a scalar step and a polarity bit. It then walks the element positions from 0 upward, one position per clock, and stops below the vector length. Whenever the mask bit of the current position matches the polarity bit, it issues one write to the destination vector register. The write carries that position's offset, which is the position number times the step. Writes land in destination elements 0, 1, 2 and onward with no gaps. Destination elements at or above the final count are never written.

When the walk ends, the block raises a one-cycle done strobe together with the number of elements it produced. That number stays on the count output until the next accepted start, so the count register of the surrounding vector unit can capture it at any time after done. The offset is kept in a running sum rather than a multiplier. Only the low 32 bits are kept, which suits the low longword of a vector element.

Top module: `iota_gen`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o and wr_en_o are low and count_o is 0.
- R2: A start accepted on a clock edge scans positions 0 to L-1 on the following L cycles, one per cycle, in increasing order. L is the effective length. done_o is high for exactly one cycle, L+1 cycles after the start edge.
- R3: A write is issued for a scanned position only when that position's mask bit equals pol_i. With pol_i=1 the set bits select positions; with pol_i=0 the clear bits do.
- R4: The n-th write of a scan (counting from 1) targets destination element n-1, so the written elements are packed from element 0.
- R5: The data of the write for position p is p multiplied by the latched stride, truncated to 32 bits.
- R6: A length above NUM_ELEM is treated as NUM_ELEM. A length of 0 produces no writes, a count of 0, and done one cycle after the start edge.
- R7: count_o equals the number of writes of the scan while done_o is high, and it keeps that value until the next accepted start.
- R8: busy_o is high from the cycle after an accepted start through the done cycle. start_i is ignored while busy_o is high, so the scan in progress keeps its mask, length, stride and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when not busy |
| mask_i | input | NUM_ELEM | Mask, one bit per element position |
| len_i | input | LEN_W | Vector length |
| stride_i | input | DATA_W | Scalar step between offsets |
| pol_i | input | 1 | Mask value that selects a position |
| busy_o | output | 1 | Scan or done cycle in progress |
| wr_en_o | output | 1 | Destination element write strobe |
| wr_idx_o | output | IDX_W | Destination element number |
| wr_data_o | output | DATA_W | Offset written to the low longword |
| done_o | output | 1 | One-cycle end-of-scan strobe |
| count_o | output | CNT_W | Number of elements produced |

## Verification
After a start is taken on edge E, the write decision for position k appears in the cycle that follows edge E+k. The done strobe and valid count follow edge E+L, and busy drops after edge E+L+1. The bench drives each start at a falling edge. It then samples exactly one falling edge per position, one more for done and the count, and a last one for the idle state with the held count. Every write and every idle cycle is therefore compared in the cycle it is due. The sweep covers every 8-bit mask, both polarities, lengths 0 to 9 and 15, and several strides, including one that wraps at 32 bits. Extra starts are injected during busy scans to show they have no effect.

// File: rtl/iota_pkg.sv
package iota_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } iota_state_e;
endpackage

// File: rtl/iota_ctrl.sv
module iota_ctrl
  import iota_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int LEN_W    = 8,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             start_acc_o,
  output logic             scan_act_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(NUM_ELEM);

  iota_state_e     state_q, state_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] len_eff;
  logic             last_pos;

  // clamp requested length to the element count
  always_comb begin
    if (32'(len_i) > NUM_ELEM) len_eff = MAX_LEN;
    else                       len_eff = CNT_W'(len_i);
  end

  assign start_acc_o = start_i && (state_q == ST_IDLE);
  assign last_pos    = (pos_q == (len_q - ONE));

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    len_d   = len_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_acc_o) begin
          pos_d   = '0;
          len_d   = len_eff;
          state_d = (len_eff == '0) ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        pos_d = pos_q + ONE;
        if (last_pos) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
    end
  end

  assign scan_act_o = (state_q == ST_SCAN);
  assign pos_o      = pos_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/iota_mask_sel.sv
module iota_mask_sel #(
  parameter int NUM_ELEM = 64,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1),
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic                pol_i,
  input  logic                scan_act_i,
  input  logic [CNT_W-1:0]    pos_i,
  output logic                hit_o
);
  logic [NUM_ELEM-1:0] mask_q, mask_d;
  logic                pol_q, pol_d;
  logic [NUM_ELEM-1:0] match;

  always_comb begin
    mask_d = mask_q;
    pol_d  = pol_q;
    if (load_i) begin
      mask_d = mask_i;
      pol_d  = pol_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
    end
  end

  // per-position polarity match
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_match
    assign match[g] = ~(mask_q[g] ^ pol_q);
  end

  assign hit_o = scan_act_i && match[pos_i[IDX_W-1:0]];
endmodule

// File: rtl/iota_offset_acc.sv
module iota_offset_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] stride_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] offset_o
);
  logic [DATA_W-1:0] stride_q, stride_d;
  logic [DATA_W-1:0] off_q, off_d;

  always_comb begin
    stride_d = stride_q;
    off_d    = off_q;
    if (load_i) begin
      stride_d = stride_i;
      off_d    = '0;
    end else if (step_i) begin
      off_d = off_q + stride_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      off_q    <= '0;
    end else begin
      stride_q <= stride_d;
      off_q    <= off_d;
    end
  end

  assign offset_o = off_q;
endmodule

// File: rtl/iota_pack_cnt.sv
module iota_pack_cnt #(
  parameter int NUM_ELEM = 64,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1),
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             hit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)    cnt_d = '0;
    else if (hit_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idx_o   = cnt_q[IDX_W-1:0];
  assign count_o = cnt_q;
endmodule

// File: rtl/iota_gen.sv
module iota_gen #(
  parameter int NUM_ELEM = 64,
  parameter int LEN_W    = 8,
  parameter int DATA_W   = 32,
  localparam int CNT_W   = $clog2(NUM_ELEM + 1),
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [DATA_W-1:0]   stride_i,
  input  logic                pol_i,
  output logic                busy_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    count_o
);
  logic             start_acc;
  logic             scan_act;
  logic [CNT_W-1:0] pos;
  logic             hit;

  iota_ctrl #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .start_acc_o(start_acc), .scan_act_o(scan_act), .pos_o(pos),
    .busy_o(busy_o), .done_o(done_o)
  );

  iota_mask_sel #(.NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .load_i(start_acc), .mask_i(mask_i),
    .pol_i(pol_i), .scan_act_i(scan_act), .pos_i(pos), .hit_o(hit)
  );

  iota_offset_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load_i(start_acc), .stride_i(stride_i),
    .step_i(scan_act), .offset_o(wr_data_o)
  );

  iota_pack_cnt #(.NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .hit_i(hit),
    .idx_o(wr_idx_o), .count_o(count_o)
  );

  assign wr_en_o = hit;
endmodule

// File: rtl/iota_gen_chk.sv
module iota_gen_chk #(
  parameter int NUM_ELEM = 64,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1),
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);
  // independent tally of writes since the last accepted start
  logic [CNT_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen_q <= '0;
    else if (start_i && !busy_o)  seen_q <= '0;
    else if (wr_en_o)             seen_q <= seen_q + CNT_W'(1);
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || wr_en_o) |-> busy_o);

  a_r3_no_write_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o);

  a_r4_packed_index: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o == seen_q[IDX_W-1:0]));

  a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (count_o == seen_q));

  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(count_o));

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind iota_gen iota_gen_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .done_o(done_o), .count_o(count_o)
);

// File: tb/iota_gen_tb.sv
`timescale 1ns/100ps
module iota_gen_tb;
  localparam int NE = 8;
  localparam int LW = 4;
  localparam int DW = 32;
  localparam int CW = $clog2(NE + 1);
  localparam int IW = $clog2(NE);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NE-1:0] mask;
  logic [LW-1:0] len;
  logic [DW-1:0] stride;
  logic          pol;
  logic          busy, wr_en, done;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;

  iota_gen #(.NUM_ELEM(NE), .LEN_W(LW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask), .len_i(len),
    .stride_i(stride), .pol_i(pol), .busy_o(busy), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(done), .count_o(count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // one complete scan; poke injects a competing start while busy (R8)
  task automatic run(input logic [NE-1:0] m, input int l, input logic [DW-1:0] s,
                     input logic p, input bit poke);
    int eff;
    int n;
    logic [DW-1:0] e;
    eff = (l > NE) ? NE : l;
    n = 0;
    @(negedge clk);
    start = 1'b1; mask = m; len = LW'(l); stride = s; pol = p;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < eff; k++) begin
      chk(busy == 1'b1, "R8 busy during scan", busy, 1);
      chk(done == 1'b0, "R2 no done during scan", done, 0);
      chk(wr_en == (m[k] == p), "R3 write select", wr_en, (m[k] == p));
      if (wr_en && (m[k] == p)) begin
        chk(wr_idx == IW'(n), "R4 packed index", wr_idx, n);
        e = s * 32'(k);
        chk(wr_data == e, "R5 offset value", wr_data, e);
        n++;
      end else if (m[k] == p) begin
        n++;
      end
      if (poke && k == 0) begin
        start = 1'b1; mask = ~m; len = LW'(15); stride = ~s; pol = ~p;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, (eff == 0) ? "R6 zero length done" : "R2 done timing", done, 1);
    chk(wr_en == 1'b0, "R3 no write at done", wr_en, 0);
    chk(count == CW'(n), (eff == 0) ? "R6 zero count" : "R7 count at done", count, n);
    chk(busy == 1'b1, "R8 busy in done cycle", busy, 1);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", done, 0);
    chk(busy == 1'b0, "R8 idle after done", busy, 0);
    chk(count == CW'(n), "R7 count held", count, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mask = '0; len = '0; stride = '0; pol = 1'b1;
    #1;
    chk(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R1 outputs in reset", {busy, done, wr_en}, 0);
    chk(count == '0, "R1 count in reset", count, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R1 outputs after reset", {busy, done, wr_en}, 0);
    chk(count == '0, "R1 count after reset", count, 0);

    // exhaustive masks, both polarities, lengths incl. zero and clamp (R6)
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l <= 10; l++) begin
        for (int m = 0; m < 256; m++) begin
          run(NE'(m), (l == 10) ? 15 : l, 32'(m * 7 + l + 1), p[0], 1'b0);
        end
      end
    end
    // 32-bit wrap of the offset (R5)
    run(8'hFF, 8, 32'hF000_0001, 1'b1, 1'b0);
    run(8'hA5, 8, 32'hFFFF_FFFF, 1'b0, 1'b0);
    // competing start while busy is ignored (R8)
    run(8'h3C, 8, 32'd4, 1'b1, 1'b1);
    run(8'h81, 5, 32'd12, 1'b0, 1'b1);
    run(8'h00, 2, 32'd3, 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule